// File: doc/BRIEF.md
# Three-ROM Microsequencer Next-Address Unit

This block is the sequencing core of a microprogrammed control unit. It holds the current microstate address in a register. It also keeps the microword read from the main control store at that address, and drives that microword's control field to the datapath. Each cycle it works out the address of the next microstate and loads both registers from it.

The next address comes from one of three sources:
- the next-state field of the current microword;
- an opcode-dispatch table, which maps the instruction opcode to the first microstate of that instruction;
- a branch-target table, which maps a 2-bit compare selector to the first microstate of a taken branch.

A 2-bit sequencing-mode field in the current microword picks the source. The microprogram places the opcode-dispatch mode only in the last of the three fetch microstates. All three tables are read-only images set through parameters. The datapath and the comparator that produces the branch condition lie outside the block.

Microword layout, most significant first: sequencing mode (2 bits), next-state address (AW bits), control field (CW bits).

With the default images (AW=6, CW=16, OPW=4), the microprogram is as follows:
- Address 0 is fetch step 1 and goes to 1.
- Address 1 is fetch step 2 and goes to 2.
- Address 2 is fetch step 3 and dispatches on the opcode.
- The opcode-dispatch table sends opcode k to address 8+k.
- At an odd opcode's entry address, the microword is a conditional branch whose next-state field is 0.
- At an even opcode's entry address, the microword goes to 0. The exception is address 22, which holds the reserved mode with a next-state field of 1.
- The branch-target table sends selector t to 32+t. The four entries are the equal, greater-than, clamp-below and clamp-above branch microstates.
- Every other microword goes to 0.
- The control field of address a is {4'hC, ~a, a}.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the unit loads microstate address 0 (fetch step 1). `ctrl_o` then shows the control field of address 0.
- R2: When the current microword's mode is 2'b00 (take next field), the next microstate is that microword's next-state field.
- R3: When the mode is 2'b01 (opcode dispatch), the next microstate is the opcode-dispatch entry indexed by `opcode_i`. With the default images, opcode k goes to 8+k.
- R4: When the mode is 2'b10 (conditional branch) and `cond_true_i` is high, the next microstate is the branch-target entry indexed by `cmp_target_i`. The selectors map as 2'b00 to equal, 2'b01 to greater-than, 2'b10 to clamp-below and 2'b11 to clamp-above. With the default images these are addresses 32, 33, 34 and 35.
- R5: When the mode is 2'b10 and `cond_true_i` is low, the next microstate is the microword's own next-state field.
- R6: The reserved mode 2'b11 behaves as 2'b00: it takes the next-state field and ignores the branch condition.
- R7: `ctrl_o` always carries the control field of the microword stored at `upc_o`. With the default images this is {4'hC, ~a, a} for address a.
- R8: `opcode_i` has no effect outside dispatch mode. `cmp_target_i` and `cond_true_i` have no effect outside conditional-branch mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | OPW | Opcode of the current instruction, used for dispatch |
| cmp_target_i | input | 2 | Compare selector into the branch-target table |
| cond_true_i | input | 1 | Branch condition from the datapath comparator |
| upc_o | output | AW | Current microstate address |
| ctrl_o | output | CW | Control field of the current microword |

## Verification
The assertions watch every cycle after reset. For each sequencing mode, they check that the following address equals the source that mode names: the next-state field, the dispatch-table output, or the branch-target output, depending on the condition. They also check that reset forces address 0. Only the bench scenarios can show that the tables hold the right entries and that `ctrl_o` carries the matching control field. The same applies to the default microprogram walking from fetch through dispatch into each branch target, and to stray opcode and condition inputs leaving the sequence untouched.

// File: rtl/useq_pkg.sv
package useq_pkg;

    localparam int DEF_AW  = 6;
    localparam int DEF_CW  = 16;
    localparam int DEF_OPW = 4;
    localparam int MODE_W  = 2;
    localparam int DEF_UW  = MODE_W + DEF_AW + DEF_CW;
    localparam int DEF_MAIN_DEPTH = 1 << DEF_AW;
    localparam int DEF_SEQ_DEPTH  = 1 << DEF_OPW;
    localparam int COND_DEPTH     = 4;

    typedef enum logic [MODE_W-1:0] {
        SEQ_NEXT     = 2'b00,
        SEQ_DISPATCH = 2'b01,
        SEQ_COND     = 2'b10,
        SEQ_RSVD     = 2'b11
    } seq_mode_e;

    // Default microprogram: three fetch steps, dispatch, one entry per opcode,
    // four branch targets.
    function automatic logic [DEF_UW*DEF_MAIN_DEPTH-1:0] default_main_image();
        logic [DEF_UW*DEF_MAIN_DEPTH-1:0] img;
        img = '0;
        for (int a = 0; a < DEF_MAIN_DEPTH; a++) begin
            logic [DEF_AW-1:0] ad;
            logic [DEF_AW-1:0] nxt;
            seq_mode_e         md;
            logic [DEF_CW-1:0] ctl;
            ad  = DEF_AW'(a);
            md  = SEQ_NEXT;
            nxt = '0;
            if (a == 0) begin
                nxt = DEF_AW'(1);
            end else if (a == 1) begin
                nxt = DEF_AW'(2);
            end else if (a == 2) begin
                md = SEQ_DISPATCH;
            end else if (a == 22) begin
                md  = SEQ_RSVD;
                nxt = DEF_AW'(1);
            end else if (a >= 8 && a < 8 + DEF_SEQ_DEPTH && ((a - 8) % 2 == 1)) begin
                md = SEQ_COND;
            end
            ctl = {4'hC, ~ad, ad};
            img[a*DEF_UW +: DEF_UW] = {md, nxt, ctl};
        end
        return img;
    endfunction

    function automatic logic [DEF_AW*DEF_SEQ_DEPTH-1:0] default_seq_image();
        logic [DEF_AW*DEF_SEQ_DEPTH-1:0] img;
        for (int k = 0; k < DEF_SEQ_DEPTH; k++) begin
            img[k*DEF_AW +: DEF_AW] = DEF_AW'(8 + k);
        end
        return img;
    endfunction

    function automatic logic [DEF_AW*COND_DEPTH-1:0] default_cond_image();
        logic [DEF_AW*COND_DEPTH-1:0] img;
        for (int t = 0; t < COND_DEPTH; t++) begin
            img[t*DEF_AW +: DEF_AW] = DEF_AW'(32 + t);
        end
        return img;
    endfunction

endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
    parameter int DEPTH = 4,
    parameter int W     = 6,
    parameter int AW    = 2,
    parameter logic [DEPTH*W-1:0] IMAGE = '0
) (
    input  logic [AW-1:0] addr,
    output logic [W-1:0]  data
);
    logic [W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = IMAGE[i*W +: W];
    end

    assign data = table_q[addr];
endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel
    import useq_pkg::*;
#(
    parameter int AW = DEF_AW
) (
    input  seq_mode_e     mode,
    input  logic [AW-1:0] next_fld,
    input  logic [AW-1:0] seq_addr,
    input  logic [AW-1:0] cond_addr,
    input  logic          cond_true,
    output logic [AW-1:0] nxt
);
    always_comb begin
        unique case (mode)
            SEQ_NEXT:     nxt = next_fld;
            SEQ_DISPATCH: nxt = seq_addr;
            SEQ_COND:     nxt = cond_true ? cond_addr : next_fld;
            SEQ_RSVD:     nxt = next_fld;
            default:      nxt = next_fld;
        endcase
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int AW  = DEF_AW,
    parameter int CW  = DEF_CW,
    parameter int OPW = DEF_OPW,
    parameter logic [(MODE_W+AW+CW)*(1<<AW)-1:0] MAIN_IMAGE = default_main_image(),
    parameter logic [AW*(1<<OPW)-1:0]            SEQ_IMAGE  = default_seq_image(),
    parameter logic [AW*COND_DEPTH-1:0]          COND_IMAGE = default_cond_image()
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode_i,
    input  logic [1:0]     cmp_target_i,
    input  logic           cond_true_i,
    output logic [AW-1:0]  upc_o,
    output logic [CW-1:0]  ctrl_o
);
    localparam int UW         = MODE_W + AW + CW;
    localparam int MAIN_DEPTH = 1 << AW;
    localparam int SEQ_DEPTH  = 1 << OPW;

    logic [UW-1:0] word_q;
    logic [AW-1:0] upc_q;
    logic [UW-1:0] fetch_word;
    logic [AW-1:0] seq_addr;
    logic [AW-1:0] cond_addr;
    logic [AW-1:0] sel_addr;
    logic [AW-1:0] fetch_addr;
    seq_mode_e     cur_mode;
    logic [AW-1:0] cur_next;

    assign cur_mode = seq_mode_e'(word_q[UW-1 -: MODE_W]);
    assign cur_next = word_q[CW +: AW];

    useq_rom #(.DEPTH(MAIN_DEPTH), .W(UW), .AW(AW), .IMAGE(MAIN_IMAGE)) u_main_rom (
        .addr(fetch_addr), .data(fetch_word)
    );

    useq_rom #(.DEPTH(SEQ_DEPTH), .W(AW), .AW(OPW), .IMAGE(SEQ_IMAGE)) u_seq_rom (
        .addr(opcode_i), .data(seq_addr)
    );

    useq_rom #(.DEPTH(COND_DEPTH), .W(AW), .AW(2), .IMAGE(COND_IMAGE)) u_cond_rom (
        .addr(cmp_target_i), .data(cond_addr)
    );

    useq_next_sel #(.AW(AW)) u_next_sel (
        .mode(cur_mode), .next_fld(cur_next), .seq_addr(seq_addr),
        .cond_addr(cond_addr), .cond_true(cond_true_i), .nxt(sel_addr)
    );

    assign fetch_addr = rst ? '0 : sel_addr;

    // State register: address and microword advance together.
    always_ff @(posedge clk) begin
        upc_q  <= fetch_addr;
        word_q <= fetch_word;
    end

    // Outputs.
    always_comb begin
        upc_o  = upc_q;
        ctrl_o = word_q[CW-1:0];
    end
endmodule

// File: rtl/useq_checker.sv
module useq_checker
    import useq_pkg::*;
#(
    parameter int AW = DEF_AW
) (
    input logic          clk,
    input logic          rst,
    input seq_mode_e     mode,
    input logic [AW-1:0] next_fld,
    input logic [AW-1:0] seq_addr,
    input logic [AW-1:0] cond_addr,
    input logic          cond_true,
    input logic [AW-1:0] upc
);
    assert_reset_to_fetch_R1: assert property (@(posedge clk)
        rst |=> (upc == '0));

    assert_take_next_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == SEQ_NEXT) |=> (upc == $past(next_fld)));

    assert_dispatch_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == SEQ_DISPATCH) |=> (upc == $past(seq_addr)));

    assert_branch_taken_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == SEQ_COND && cond_true) |=> (upc == $past(cond_addr)));

    assert_branch_fallthru_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == SEQ_COND && !cond_true) |=> (upc == $past(next_fld)));

    assert_reserved_next_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == SEQ_RSVD) |=> (upc == $past(next_fld)));
endmodule

bind useq_top useq_checker #(.AW(AW)) u_useq_chk (
    .clk(clk), .rst(rst), .mode(cur_mode), .next_fld(cur_next),
    .seq_addr(seq_addr), .cond_addr(cond_addr), .cond_true(cond_true_i),
    .upc(upc_o)
);

// File: tb/test_useq_top.sv
module test_useq_top;
    localparam int AW  = 6;
    localparam int CW  = 16;
    localparam int OPW = 4;
    localparam int NV  = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [OPW-1:0] opcode = '0;
    logic [1:0]     tgt = '0;
    logic           cnd = 1'b0;
    logic [AW-1:0]  upc;
    logic [CW-1:0]  ctrl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    useq_top i_useq_top (
        .clk(clk), .rst(rst), .opcode_i(opcode), .cmp_target_i(tgt),
        .cond_true_i(cnd), .upc_o(upc), .ctrl_o(ctrl)
    );

    // Vector: {rst, opcode, cmp_target, cond_true, expected address}
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 4'd0,  2'd0, 1'b0, 6'd0},   // R1
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd1},   // R2
        {1'b0, 4'd15, 2'd3, 1'b1, 6'd2},   // R8 noise during plain step
        {1'b0, 4'd5,  2'd0, 1'b0, 6'd13},  // R3
        {1'b0, 4'd0,  2'd0, 1'b1, 6'd32},  // R4 equal
        {1'b0, 4'd9,  2'd2, 1'b1, 6'd0},   // R8
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd1},
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd2},
        {1'b0, 4'd7,  2'd0, 1'b0, 6'd15},  // R3
        {1'b0, 4'd0,  2'd1, 1'b1, 6'd33},  // R4 greater-than
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd0},
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd1},
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd2},
        {1'b0, 4'd9,  2'd0, 1'b0, 6'd17},  // R3
        {1'b0, 4'd0,  2'd2, 1'b1, 6'd34},  // R4 clamp-below
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd0},
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd1},
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd2},
        {1'b0, 4'd11, 2'd0, 1'b0, 6'd19},  // R3
        {1'b0, 4'd0,  2'd3, 1'b1, 6'd35},  // R4 clamp-above
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd0},
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd1},
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd2},
        {1'b0, 4'd3,  2'd0, 1'b0, 6'd11},  // R3
        {1'b0, 4'd0,  2'd3, 1'b0, 6'd0},   // R5
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd1},
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd2},
        {1'b0, 4'd14, 2'd0, 1'b0, 6'd22},  // R3
        {1'b0, 4'd5,  2'd1, 1'b1, 6'd1},   // R6 reserved ignores condition
        {1'b0, 4'd0,  2'd0, 1'b0, 6'd2},
        {1'b0, 4'd4,  2'd0, 1'b0, 6'd12},  // R3
        {1'b0, 4'd0,  2'd2, 1'b1, 6'd0}    // R2 even-opcode step
    };

    function automatic logic [CW-1:0] exp_ctrl(input logic [AW-1:0] a);
        return {4'hC, ~a, a};
    endfunction

    task automatic check_state(input logic [AW-1:0] exp, input string req);
        n_tests++;
        if (upc !== exp) begin
            n_fail++;
            $display("FAIL %s upc actual=%0d expected=%0d", req, upc, exp);
        end
        n_tests++;
        if (ctrl !== exp_ctrl(exp)) begin
            n_fail++;
            $display("FAIL R7 ctrl actual=%h expected=%h", ctrl, exp_ctrl(exp));
        end
    endtask

    task automatic step(input logic r, input logic [OPW-1:0] op,
                        input logic [1:0] t, input logic c);
        rst = r; opcode = op; tgt = t; cnd = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][13], VEC[i][12:9], VEC[i][8:7], VEC[i][6]);
            check_state(VEC[i][5:0], "R2/R3/R4/R5/R6/R8 vector");
        end
        // R1: reset in the middle of an instruction.
        step(1'b0, 4'd0, 2'd0, 1'b0);
        step(1'b0, 4'd0, 2'd0, 1'b0);
        step(1'b0, 4'd6, 2'd0, 1'b0);
        check_state(6'd14, "R3 dispatch before reset");
        step(1'b1, 4'd0, 2'd0, 1'b1);
        check_state(6'd0, "R1 reset mid-instruction");
        // R1: reset wins over dispatch at fetch step 3.
        step(1'b0, 4'd0, 2'd0, 1'b0);
        step(1'b0, 4'd0, 2'd0, 1'b0);
        step(1'b1, 4'd9, 2'd0, 1'b0);
        check_state(6'd0, "R1 reset over dispatch");
        // R8: branch inputs during fetch do not disturb the sequence.
        step(1'b0, 4'd3, 2'd1, 1'b1);
        check_state(6'd1, "R8 fetch ignores branch inputs");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            if (done) break;
            @(posedge clk);
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule